// File: doc/BRIEF.md
# Four-Port PS/2 Shift Controller

This block puts one PS/2 bit-shift engine in front of four independent PS/2 ports. Every port has its own clock and data line. Each line is open-drain: the block only ever pulls a line low or leaves it released. Firmware controls the lines through a small register file. For each port, one bit lets that port's clock run and another bit releases its data line. Firmware also turns the engine on, picks receive or transmit mode, and chooses an input debounce length.

The first port to show a start bit, which is a falling clock edge while data is low, takes the engine. The engine then records that port as active and reports it with a sparse code. It raises a start flag, moves through the 11-bit frame, and raises an end flag when the frame is complete. For a received frame, the block checks odd parity and the stop bit. For a transmitted frame, it checks that the device pulled data low as an acknowledge. Start bits on the other ports are ignored while a port is held. Every flag stays set until firmware clears all four clock-enable bits, which resets the engine for the next transaction. The interrupt output and the wake output are both masked copies of the flags.

Top module: `ps2_shift_hub`

## Requirements
- R1: After reset the registers read as follows: control (address 0) = 0x00, line register (address 1) = 0x47, status (address 2) = 0x00, data (address 3) = 0x00, interrupt enable (address 4) = 0x00. A write to address 2 has no effect.
- R2: Clock-enable bits for ports 0..3 are line-register bits 3, 4, 5 and 7. Data-release bits for ports 0..3 are bits 0, 1, 2 and 6. `ps2_clk_low_o[n]` is 1 exactly when the clock-enable bit of port n is 0. Outside an active transmit on port n, `ps2_dat_low_o[n]` is 1 exactly when the data-release bit of port n is 0.
- R3: Status bits 6:4 hold the active-port code: 0 when no port is held, 1 for port 0, 2 for port 1, 4 for port 2 and 5 for port 3.
- R4: With the engine on (control bit 0), a falling clock edge with data low on a port whose clock is enabled latches that port. It also sets the start flag (status bit 0). All flags and the active code stay set until the four clock-enable bits are all 0 for a cycle. That cycle clears them.
- R5: In receive mode, the frame consists of a 0 start bit, eight data bits sent LSB first, one odd-parity bit and a 1 stop bit. Each bit is sampled on a falling clock edge. The stop-bit edge sets the end flag (status bit 1). When the frame is valid, the byte is loaded into the data register.
- R6: When a received frame fails odd parity, the parity-error flag (status bit 2) is set and the data register keeps its previous value.
- R7: When a received stop bit is 0, the frame-error flag (status bit 3) is set and the data register keeps its previous value.
- R8: While a port is latched, start bits on the other ports are ignored. When start bits arrive on several ports in the same cycle, the lowest-numbered port wins.
- R9: In transmit mode (control bit 1), the latched port's data line comes from the engine. After falling edges 1 to 8 it carries the data register LSB first. After edge 9 it carries the odd parity bit. After edge 10 it is released. Edge 11 samples the acknowledge and sets the end flag. If the acknowledge is high, the frame-error flag is also set.
- R10: Control bits 5:3 hold a debounce code k, from 0 to 5 (values above 5 act as 5). A new pin level is accepted only after it has been steady for 2^k cycles, so a shorter pulse has no effect.
- R11: `irq_o` = (start flag AND interrupt-enable bit 0) OR (end flag AND interrupt-enable bit 1). `wake_o` = start flag AND interrupt-enable bit 4. `pullup_en_o` follows control bit 2.
- R12: While control bit 0 is 0, no start bit is latched and the status register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational) |
| ps2_clk_i | input | 4 | Sensed level of the four clock lines |
| ps2_dat_i | input | 4 | Sensed level of the four data lines |
| ps2_clk_low_o | output | 4 | Pull each clock line low |
| ps2_dat_low_o | output | 4 | Pull each data line low |
| irq_o | output | 1 | Masked start/end interrupt |
| wake_o | output | 1 | Masked wake request on start |
| pullup_en_o | output | 1 | Weak pull-up enable for the pads |

## Verification
Two starts in the same cycle are the case where port selection and the ignore rule collide. Arbitration picks a winner, and the same edge must also lock out the losing port for the rest of its frame. The bench drives ports 1 and 3 from a single device task with identical bit timing, so both start bits reach the engine on the same edge. The run passes only if the status code reads 2 and the data register holds the frame byte. The ignore rule also requires that port 3's continuing clock edges, which would otherwise be parsed as its own start and data bits, leave every flag untouched.

// File: rtl/ps2_shift_hub.sv
module ps2_shift_hub #(
  parameter int CW = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic [2:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic [3:0] ps2_clk_i,
  input  logic [3:0] ps2_dat_i,
  output logic [3:0] ps2_clk_low_o,
  output logic [3:0] ps2_dat_low_o,
  output logic       irq_o,
  output logic       wake_o,
  output logic       pullup_en_o
);
  localparam int NL = 8;

  logic [7:0] ctrl_q, sig_q, ien_q, data_q, sh_q;
  logic [NL-1:0] sync_q, filt_q;
  logic [CW-1:0] cnt_q [NL];
  logic [3:0] prev_q, bitcnt_q;
  logic [1:0] act_q;
  logic act_v_q, sot_q, eot_q, perr_q, ferr_q, txm_q, par_q;

  logic [3:0] clk_en, dat_rel, fclk, fdat, fall;
  logic [2:0] dbsel, code;
  logic [CW-1:0] dblim;
  logic mech_rst, st_hit, afall, adat, tx_bit;
  logic [1:0] st_ch;

  assign clk_en  = {sig_q[7], sig_q[5], sig_q[4], sig_q[3]};
  assign dat_rel = {sig_q[6], sig_q[2], sig_q[1], sig_q[0]};
  assign dbsel   = (ctrl_q[5:3] > 3'd5) ? 3'd5 : ctrl_q[5:3];
  assign dblim   = CW'((1 << dbsel) - 1);
  assign fclk    = filt_q[3:0];
  assign fdat    = filt_q[7:4];
  assign fall    = prev_q & ~fclk;
  assign mech_rst = (clk_en == 4'b0000) || !ctrl_q[0];
  assign afall   = fall[act_q];
  assign adat    = fdat[act_q];

  always_comb begin
    st_hit = 1'b0;
    st_ch  = 2'd0;
    for (int i = 3; i >= 0; i--)
      if (fall[i] && clk_en[i] && !fdat[i]) begin
        st_hit = 1'b1;
        st_ch  = 2'(i);
      end
  end

  always_comb begin
    if (bitcnt_q >= 4'd1 && bitcnt_q <= 4'd8) tx_bit = data_q[3'(bitcnt_q - 4'd1)];
    else if (bitcnt_q == 4'd9)                tx_bit = ~^data_q;
    else                                      tx_bit = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      filt_q <= '1;
      prev_q <= '1;
      for (int i = 0; i < NL; i++) cnt_q[i] <= '0;
    end else begin
      sync_q <= {ps2_dat_i, ps2_clk_i};
      prev_q <= fclk;
      for (int i = 0; i < NL; i++) begin
        if (sync_q[i] != filt_q[i]) begin
          if (cnt_q[i] == dblim) begin
            filt_q[i] <= sync_q[i];
            cnt_q[i]  <= '0;
          end else cnt_q[i] <= cnt_q[i] + 1'b1;
        end else cnt_q[i] <= '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= 8'h00; sig_q <= 8'h47; ien_q <= 8'h00; data_q <= 8'h00;
      sh_q <= 8'h00; par_q <= 1'b0; bitcnt_q <= 4'd0; act_q <= 2'd0;
      act_v_q <= 1'b0; sot_q <= 1'b0; eot_q <= 1'b0;
      perr_q <= 1'b0; ferr_q <= 1'b0; txm_q <= 1'b0;
    end else begin
      if (bus_wr) begin
        case (bus_addr)
          3'd0: ctrl_q <= bus_wdata;
          3'd1: sig_q  <= bus_wdata;
          3'd3: data_q <= bus_wdata;
          3'd4: ien_q  <= bus_wdata & 8'h93;
          default: ;
        endcase
      end
      if (mech_rst) begin
        act_v_q <= 1'b0; sot_q <= 1'b0; eot_q <= 1'b0;
        perr_q <= 1'b0; ferr_q <= 1'b0; bitcnt_q <= 4'd0; txm_q <= 1'b0;
      end else if (!act_v_q) begin
        if (st_hit) begin
          act_v_q <= 1'b1; act_q <= st_ch; sot_q <= 1'b1;
          bitcnt_q <= 4'd1; txm_q <= ctrl_q[1];
        end
      end else if (afall && bitcnt_q != 4'd11) begin
        if (bitcnt_q == 4'd10) begin
          eot_q <= 1'b1;
          bitcnt_q <= 4'd11;
          if (txm_q) ferr_q <= adat;
          else begin
            perr_q <= ~^{sh_q, par_q};
            ferr_q <= ~adat;
            if (adat && ^{sh_q, par_q}) data_q <= sh_q;
          end
        end else begin
          bitcnt_q <= bitcnt_q + 4'd1;
          if (!txm_q) begin
            if (bitcnt_q <= 4'd8) sh_q <= {adat, sh_q[7:1]};
            else par_q <= adat;
          end
        end
      end
    end
  end

  always_comb
    for (int i = 0; i < 4; i++)
      ps2_dat_low_o[i] = (act_v_q && txm_q && act_q == 2'(i)) ? ~tx_bit : ~dat_rel[i];

  assign ps2_clk_low_o = ~clk_en;
  assign code = !act_v_q ? 3'd0 : (act_q == 2'd0) ? 3'd1 : (act_q == 2'd1) ? 3'd2 :
                (act_q == 2'd2) ? 3'd4 : 3'd5;

  always_comb begin
    case (bus_addr)
      3'd0: bus_rdata = ctrl_q;
      3'd1: bus_rdata = sig_q;
      3'd2: bus_rdata = {1'b0, code, ferr_q, perr_q, eot_q, sot_q};
      3'd3: bus_rdata = data_q;
      3'd4: bus_rdata = ien_q;
      default: bus_rdata = 8'h00;
    endcase
  end

  assign irq_o       = (sot_q & ien_q[0]) | (eot_q & ien_q[1]);
  assign wake_o      = sot_q & ien_q[4];
  assign pullup_en_o = ctrl_q[2];
endmodule

// File: rtl/ps2_shift_hub_sva.sv
module ps2_shift_hub_sva (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] sig_q,
  input logic       eng_on,
  input logic       act_v_q,
  input logic [1:0] act_q,
  input logic       sot_q,
  input logic       eot_q,
  input logic       perr_q,
  input logic       ferr_q,
  input logic       irq_o
);
  logic all_low;
  assign all_low = ({sig_q[7], sig_q[5:3]} == 4'b0000);

  a_r4_flags_clear: assert property (@(posedge clk) disable iff (!rst_n)
    all_low |=> (!sot_q && !eot_q && !act_v_q));
  a_r4_start_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (sot_q && !all_low && eng_on) |=> sot_q);
  a_r3_start_has_port: assert property (@(posedge clk) disable iff (!rst_n)
    sot_q |-> act_v_q);
  a_r5_end_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    eot_q |-> sot_q);
  a_r6_err_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_q || ferr_q) |-> eot_q);
  a_r8_port_held: assert property (@(posedge clk) disable iff (!rst_n)
    (act_v_q && !all_low && eng_on) |=> (act_v_q && $stable(act_q)));
  a_r11_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (sot_q || eot_q));
endmodule

bind ps2_shift_hub ps2_shift_hub_sva u_sva (
  .clk(clk), .rst_n(rst_n), .sig_q(sig_q), .eng_on(ctrl_q[0]),
  .act_v_q(act_v_q), .act_q(act_q), .sot_q(sot_q), .eot_q(eot_q),
  .perr_q(perr_q), .ferr_q(ferr_q), .irq_o(irq_o)
);

// File: tb/ps2_shift_hub_test.sv
module ps2_shift_hub_test;
  localparam int HALF = 20;
  // {port[19:18], byte[17:10], flip parity[9], stop bit[8], expected status[7:0]}
  localparam logic [19:0] VEC [7] = '{
    {2'd0, 8'hA5, 1'b0, 1'b1, 8'h13},
    {2'd1, 8'h3C, 1'b0, 1'b1, 8'h23},
    {2'd2, 8'h00, 1'b0, 1'b1, 8'h43},
    {2'd3, 8'hFF, 1'b0, 1'b1, 8'h53},
    {2'd1, 8'h5A, 1'b1, 1'b1, 8'h27},
    {2'd2, 8'h81, 1'b0, 1'b0, 8'h4B},
    {2'd3, 8'h7E, 1'b1, 1'b0, 8'h5F}
  };

  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [7:0] bus_wdata = 8'h00, bus_rdata;
  logic [3:0] dev_clk = 4'hF, dev_dat = 4'hF;
  logic [3:0] ps2_clk_low_o, ps2_dat_low_o, ln_clk, ln_dat;
  logic irq_o, wake_o, pullup_en_o;
  int checks = 0, fails = 0;

  assign ln_clk = dev_clk & ~ps2_clk_low_o;
  assign ln_dat = dev_dat & ~ps2_dat_low_o;

  always #10 clk = ~clk;

  ps2_shift_hub uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ps2_clk_i(ln_clk),
    .ps2_dat_i(ln_dat), .ps2_clk_low_o(ps2_clk_low_o),
    .ps2_dat_low_o(ps2_dat_low_o), .irq_o(irq_o), .wake_o(wake_o),
    .pullup_en_o(pullup_en_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [3:0] m, input logic [7:0] b, input logic pf, input logic sb);
    logic [10:0] bits;
    bits = {sb, (~^b) ^ pf, b, 1'b0};
    for (int k = 0; k < 11; k++) begin
      @(negedge clk);
      dev_dat = (dev_dat & ~m) | (bits[k] ? m : 4'h0);
      idle(HALF);
      dev_clk = dev_clk & ~m;
      idle(HALF);
      dev_clk = dev_clk | m;
    end
    idle(HALF);
    dev_dat = dev_dat | m;
    idle(HALF);
  endtask

  task automatic dev_take(input int ch, input logic ack, output logic [7:0] b,
                          output logic p, output logic s);
    for (int k = 1; k <= 10; k++) begin
      dev_clk[ch] = 1'b0;
      idle(HALF);
      dev_clk[ch] = 1'b1;
      idle(2);
      if (k <= 8) b[k-1] = ln_dat[ch];
      else if (k == 9) p = ln_dat[ch];
      else s = ln_dat[ch];
      idle(HALF);
    end
    if (ack) dev_dat[ch] = 1'b0;
    idle(HALF);
    dev_clk[ch] = 1'b0;
    idle(HALF);
    dev_clk[ch] = 1'b1;
    idle(HALF);
    dev_dat[ch] = 1'b1;
    idle(HALF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v, last_good, tb;
    logic tp, ts;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    rd(3'd0, v); chk("R1 control", v, 8'h00);
    rd(3'd1, v); chk("R1 line reg", v, 8'h47);
    rd(3'd2, v); chk("R1 status", v, 8'h00);
    rd(3'd3, v); chk("R1 data", v, 8'h00);
    rd(3'd4, v); chk("R1 ien", v, 8'h00);
    chk("R2 reset clocks low", ps2_clk_low_o, 4'hF);
    chk("R2 reset data released", ps2_dat_low_o, 4'h0);
    wr(3'd2, 8'hFF); rd(3'd2, v); chk("R1 status write ignored", v, 8'h00);

    // R12 engine off
    wr(3'd1, 8'hFF);
    idle(10);
    send_frame(4'b0001, 8'h11, 1'b0, 1'b1);
    rd(3'd2, v); chk("R12 status with engine off", v, 8'h00);
    rd(3'd3, v); chk("R12 data untouched", v, 8'h00);

    wr(3'd0, 8'h05);
    chk("R11 pullup follows control", pullup_en_o, 1'b1);
    wr(3'd4, 8'h02);
    last_good = 8'h00;
    for (int i = 0; i < 7; i++) begin
      logic [19:0] e;
      e = VEC[i];
      wr(3'd1, 8'h47);
      idle(5);
      wr(3'd1, 8'hFF);
      idle(10);
      chk("R11 irq low before frame", irq_o, 1'b0);
      send_frame(4'b0001 << e[19:18], e[17:10], e[9], e[8]);
      idle(100);
      if (!e[9] && e[8]) last_good = e[17:10];
      rd(3'd2, v); chk("R3 R5 R6 R7 status after frame", v, {24'd0, e[7:0]});
      rd(3'd3, v); chk("R5 R6 R7 data register", v, last_good);
      chk("R11 irq on end", irq_o, 1'b1);
    end

    // R4 clear via all clocks low
    wr(3'd1, 8'h47);
    idle(3);
    rd(3'd2, v); chk("R4 flags cleared", v, 8'h00);

    // R8 simultaneous start on ports 1 and 3
    wr(3'd1, 8'hFF);
    idle(10);
    send_frame(4'b1010, 8'h6D, 1'b0, 1'b1);
    rd(3'd2, v); chk("R8 lowest port wins", v, 8'h23);
    rd(3'd3, v); chk("R8 byte from winner", v, 8'h6D);
    send_frame(4'b0001, 8'h99, 1'b0, 1'b1);
    rd(3'd2, v); chk("R8 other port ignored status", v, 8'h23);
    rd(3'd3, v); chk("R8 other port ignored data", v, 8'h6D);

    // R10 debounce of 4 cycles, R11 wake
    wr(3'd1, 8'h47);
    wr(3'd0, 8'h11);
    wr(3'd4, 8'h10);
    wr(3'd1, 8'hFF);
    idle(20);
    dev_dat[0] = 1'b0;
    idle(20);
    dev_clk[0] = 1'b0;
    idle(2);
    dev_clk[0] = 1'b1;
    idle(20);
    rd(3'd2, v); chk("R10 short pulse ignored", v, 8'h00);
    chk("R11 wake low", wake_o, 1'b0);
    dev_clk[0] = 1'b0;
    idle(20);
    rd(3'd2, v); chk("R10 steady pulse accepted", v, 8'h11);
    chk("R11 wake on start", wake_o, 1'b1);
    chk("R11 irq masked", irq_o, 1'b0);
    dev_clk[0] = 1'b1;
    dev_dat[0] = 1'b1;
    wr(3'd1, 8'h47);
    idle(40);

    // R9 transmit on port 2 with acknowledge
    wr(3'd0, 8'h03);
    wr(3'd4, 8'h00);
    idle(20);
    wr(3'd3, 8'hC4);
    wr(3'd1, 8'h63);
    idle(10);
    chk("R2 clocks low except port 2", ps2_clk_low_o, 4'b1011);
    chk("R2 port 2 data pulled low", ps2_dat_low_o, 4'b0100);
    dev_take(2, 1'b1, tb, tp, ts);
    chk("R9 byte shifted out", tb, 8'hC4);
    chk("R9 odd parity", tp, ~^8'hC4);
    chk("R9 stop released", ts, 1'b1);
    rd(3'd2, v); chk("R9 status with ack", v, 8'h43);
    chk("R9 data line released after frame", ps2_dat_low_o[2], 1'b0);

    // R9 missing acknowledge
    wr(3'd1, 8'h47);
    idle(20);
    wr(3'd3, 8'h35);
    wr(3'd1, 8'h63);
    idle(10);
    dev_take(2, 1'b0, tb, tp, ts);
    chk("R9 second byte", tb, 8'h35);
    rd(3'd2, v); chk("R9 missing ack frame error", v, 8'h4B);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule